// File: doc/BRIEF.md
# Stacked-Die Wrapper Instruction Register and Mode Decoder

This block holds the instruction of a die-level test wrapper in a vertically stacked die assembly and turns it into the select lines that steer the wrapper's multiplexers. An instruction enters bit by bit on a serial input while the instruction-select control is high. It sits in a shift stage and only becomes the active mode on an update event. The decoder splits the active instruction into three choices: serial or parallel access, which chain to route (internal test, external test or bypass), and whether the test path turns back down at this die or rises to the die above. The pre-bond or post-bond choice does not come from the instruction. A pad-level input supplies it.

Some select lines depend only on the stored mode. Others also use the live wrapper controls. The boundary-cell shift select follows the shift control. The serial turn select is forced to the rising (elevator) path while an instruction is loaded, so the serial path up the stack stays open. A combination that makes no sense for the die's bond state, or an undefined instruction code, puts every select on the functional path.

Top module: `stack_wir_top`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) loads the instruction `5'b00100`, which is serial, post-bond, bypass, turn: chain_sel=01, par_sel=0, par_turn_sel=1, probe_sel=0, and ser_turn_sel=1 while sel_ir is low.
- R2: While sel_ir and shift_en are high, each clock edge shifts ser_in into the top bit of the shift stage and moves every bit down one place. ir_so shows bit 0 of the shift stage. The decoded outputs do not change while this happens.
- R3: A clock edge with sel_ir and update_en high copies the shift stage into the active instruction, and the outputs reflect it right after that edge. A clock edge with sel_ir and capture_en high (and shift_en low) loads the active instruction into the shift stage.
- R4: Instruction fields: bit 0 chooses parallel (1) or serial (0), bit 1 chooses elevator (1) or turn (0), bits [3:2] give the chain type (01 bypass, 10 extest, 11 intest, 00 undefined). Bit 4 must be 0. chain_sel reports 00 functional, 01 bypass, 10 extest, 11 intest.
- R5: The input-cell and output-cell selects are complementary in test modes: intest gives in_cell_sel=1, out_cell_sel=0; extest gives 0 and 1; bypass gives 0 and 0.
- R6: In intest and extest, bnd_shift_sel follows shift_en combinationally. In bypass and functional modes it stays 0.
- R7: par_turn_sel equals the turn bit (inverse of bit 1) of a valid mode. ser_turn_sel equals that value ANDed with the inverse of sel_ir, so it is 0 whenever sel_ir is high.
- R8: With pad_prebond high, a valid mode drives probe_sel=1. Extest or elevator combined with pad_prebond high is invalid.
- R9: data_shift_en equals shift_en AND NOT sel_ir. Shift and update activity with sel_ir low leaves the active instruction unchanged.
- R10: An invalid mode (undefined type, nonzero bit 4, or an R8 conflict) drives chain_sel=00 and all other selects to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_ir | input | 1 | High: serial port addresses the instruction register |
| shift_en | input | 1 | Live shift control |
| capture_en | input | 1 | Capture control |
| update_en | input | 1 | Update control |
| ser_in | input | 1 | Serial data input |
| pad_prebond | input | 1 | Pad-derived bond state, 1 = pre-bond (probe pads) |
| ir_so | output | 1 | Serial output of the instruction shift stage |
| data_shift_en | output | 1 | Shift enable for the data path |
| chain_sel | output | 2 | Routed chain: 00 functional, 01 bypass, 10 extest, 11 intest |
| par_sel | output | 1 | Parallel port selected |
| ser_turn_sel | output | 1 | Serial path turns down (1) or rises (0) |
| par_turn_sel | output | 1 | Parallel path turns down (1) or rises (0) |
| probe_sel | output | 1 | Test access taken from probe pads |
| bnd_shift_sel | output | 1 | Boundary-cell shift select |
| in_cell_sel | output | 1 | Input boundary-cell select |
| out_cell_sel | output | 1 | Output boundary-cell select |

## Verification
Stored-mode selects are due just after the clock edge that carried update_en with sel_ir. The bench drives the controls on falling edges and reads the outputs 1 ns after the falling edge that follows that update edge. The live-combined selects (bnd_shift_sel, ser_turn_sel, data_shift_en) involve no register. They are read 1 ns after the control changes, and no rising edge falls in that gap. Stability during shifting is checked at the falling edges between shift edges, before any update edge occurs.

// File: rtl/stack_wir_pkg.sv
// Shared types for the stacked-die wrapper instruction logic.
// Assumes a 2-bit chain code visible at the block's ports.
package stack_wir_pkg;

    typedef enum logic [1:0] {
        CH_FUNC   = 2'b00,
        CH_BYPASS = 2'b01,
        CH_EXTEST = 2'b10,
        CH_INTEST = 2'b11
    } chain_e;

    typedef struct packed {
        logic   valid;
        chain_e chain;
        logic   par;
        logic   elev;
        logic   pre;
    } wir_dec_t;

endpackage

// File: rtl/stack_wir_shift.sv
// Instruction shift stage and active instruction register.
// Works only while sel_ir is high. Shift has priority over capture.
// The active register changes only on update, so decoded selects stay
// steady while bits are moving.
module stack_wir_shift #(
    parameter int          IR_W       = 5,
    parameter logic [IR_W-1:0] RESET_CODE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_ir,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            update_en,
    input  logic            ser_in,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    logic [IR_W-1:0] sr_q;

    // Shift stage: serial load toward bit 0, or capture of the active code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= RESET_CODE;
        else if (sel_ir && shift_en)
            sr_q <= {ser_in, sr_q[IR_W-1:1]};
        else if (sel_ir && capture_en)
            sr_q <= ir_q;
    end

    // Active instruction: takes the shift stage on update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= RESET_CODE;
        else if (sel_ir && update_en)
            ir_q <= sr_q;
    end

    assign ir_so = sr_q[0];

    // R3: the active instruction moves only after an update event.
    a_r3_ir_update_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ir && update_en) |=> $stable(ir_q));

endmodule

// File: rtl/stack_wir_decode.sv
// Splits the active instruction into access, chain and direction fields
// and checks them against the pad bond state. Field positions are fixed
// (bit0 parallel, bit1 elevator, bits[3:2] type). Chain type codes are
// parameters. Bits above bit 3 must be zero.
module stack_wir_decode
    import stack_wir_pkg::*;
#(
    parameter int         IR_W      = 5,
    parameter logic [1:0] OP_BYPASS = 2'b01,
    parameter logic [1:0] OP_EXTEST = 2'b10,
    parameter logic [1:0] OP_INTEST = 2'b11
) (
    input  logic [IR_W-1:0] ir_q,
    input  logic            pad_prebond,
    output wir_dec_t        dec
);

    localparam int TYPE_LO = 2;
    localparam int TYPE_HI = 3;

    logic   upper_set;
    logic [1:0] op;
    chain_e raw_chain;
    logic   ok;

    generate
        if (IR_W > TYPE_HI + 1) begin : g_upper
            assign upper_set = |ir_q[IR_W-1:TYPE_HI+1];
        end else begin : g_no_upper
            assign upper_set = 1'b0;
        end
    endgenerate

    assign op = ir_q[TYPE_HI:TYPE_LO];

    // Chain type lookup from the parameterized type codes.
    always_comb begin
        if (op == OP_INTEST)      raw_chain = CH_INTEST;
        else if (op == OP_EXTEST) raw_chain = CH_EXTEST;
        else if (op == OP_BYPASS) raw_chain = CH_BYPASS;
        else                      raw_chain = CH_FUNC;
    end

    // Legality: defined type, clean upper bits, no pre-bond conflicts.
    always_comb begin
        ok = (raw_chain != CH_FUNC) && !upper_set &&
             !(pad_prebond && ((raw_chain == CH_EXTEST) || ir_q[1]));
        dec.valid = ok;
        dec.chain = ok ? raw_chain : CH_FUNC;
        dec.par   = ok && ir_q[0];
        dec.elev  = ok && ir_q[1];
        dec.pre   = ok && pad_prebond;
    end

endmodule

// File: rtl/stack_wir_select.sv
// Merges the decoded mode with the live wrapper controls into the mux
// selects. Purely combinational. An invalid mode yields all-zero selects.
module stack_wir_select
    import stack_wir_pkg::*;
(
    input  wir_dec_t   dec,
    input  logic       shift_en,
    input  logic       sel_ir,
    output logic [1:0] chain_sel,
    output logic       par_sel,
    output logic       ser_turn_sel,
    output logic       par_turn_sel,
    output logic       probe_sel,
    output logic       bnd_shift_sel,
    output logic       in_cell_sel,
    output logic       out_cell_sel,
    output logic       data_shift_en
);

    logic cell_mode;

    // Select generation from stored mode plus live controls.
    always_comb begin
        cell_mode     = dec.valid && ((dec.chain == CH_INTEST) || (dec.chain == CH_EXTEST));
        chain_sel     = dec.chain;
        in_cell_sel   = dec.valid && (dec.chain == CH_INTEST);
        out_cell_sel  = dec.valid && (dec.chain == CH_EXTEST);
        bnd_shift_sel = cell_mode && shift_en;
        par_sel       = dec.valid && dec.par;
        par_turn_sel  = dec.valid && !dec.elev;
        ser_turn_sel  = dec.valid && !dec.elev && !sel_ir;
        probe_sel     = dec.valid && dec.pre;
        data_shift_en = shift_en && !sel_ir;
    end

endmodule

// File: rtl/stack_wir_top.sv
// Top of the stacked-die wrapper instruction register and mode decoder.
// Assumes the wrapper controls are synchronous to clk and that the
// pre-bond pad input is static during a test.
module stack_wir_top
    import stack_wir_pkg::*;
#(
    parameter int         IR_W      = 5,
    parameter logic [1:0] OP_BYPASS = 2'b01,
    parameter logic [1:0] OP_EXTEST = 2'b10,
    parameter logic [1:0] OP_INTEST = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_ir,
    input  logic       shift_en,
    input  logic       capture_en,
    input  logic       update_en,
    input  logic       ser_in,
    input  logic       pad_prebond,
    output logic       ir_so,
    output logic       data_shift_en,
    output logic [1:0] chain_sel,
    output logic       par_sel,
    output logic       ser_turn_sel,
    output logic       par_turn_sel,
    output logic       probe_sel,
    output logic       bnd_shift_sel,
    output logic       in_cell_sel,
    output logic       out_cell_sel
);

    // Reset mode: bypass type, turn, serial.
    localparam logic [IR_W-1:0] RESET_CODE = IR_W'({OP_BYPASS, 2'b00});

    logic [IR_W-1:0] ir_q;
    wir_dec_t        dec;

    stack_wir_shift #(.IR_W(IR_W), .RESET_CODE(RESET_CODE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_ir     (sel_ir),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .ser_in     (ser_in),
        .ir_q       (ir_q),
        .ir_so      (ir_so)
    );

    stack_wir_decode #(
        .IR_W(IR_W), .OP_BYPASS(OP_BYPASS), .OP_EXTEST(OP_EXTEST), .OP_INTEST(OP_INTEST)
    ) u_decode (
        .ir_q        (ir_q),
        .pad_prebond (pad_prebond),
        .dec         (dec)
    );

    stack_wir_select u_select (
        .dec           (dec),
        .shift_en      (shift_en),
        .sel_ir        (sel_ir),
        .chain_sel     (chain_sel),
        .par_sel       (par_sel),
        .ser_turn_sel  (ser_turn_sel),
        .par_turn_sel  (par_turn_sel),
        .probe_sel     (probe_sel),
        .bnd_shift_sel (bnd_shift_sel),
        .in_cell_sel   (in_cell_sel),
        .out_cell_sel  (out_cell_sel),
        .data_shift_en (data_shift_en)
    );

    // R5: the two boundary-cell selects are never both high.
    a_r5_cells_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_cell_sel && out_cell_sel));

    // R7: loading an instruction always opens the rising serial path.
    a_r7_serial_rises_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ir |-> !ser_turn_sel);

    // R8: probe access never pairs with extest or elevator.
    a_r8_prebond_legal: assert property (@(posedge clk) disable iff (!rst_n)
        probe_sel |-> (!out_cell_sel && par_turn_sel));

    // R6: bypass never shifts boundary cells.
    a_r6_bypass_no_cell_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel == 2'b01) |-> !bnd_shift_sel);

    // R10: functional routing leaves every test select low.
    a_r10_functional_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel == 2'b00) |-> !(par_sel || probe_sel || in_cell_sel || out_cell_sel ||
                                   bnd_shift_sel || par_turn_sel || ser_turn_sel));

endmodule

// File: tb/stack_wir_top_bench.sv
module stack_wir_top_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_ir = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic ser_in = 1'b0, pad_prebond = 1'b0;
    logic ir_so, data_shift_en, par_sel, ser_turn_sel, par_turn_sel;
    logic probe_sel, bnd_shift_sel, in_cell_sel, out_cell_sel;
    logic [1:0] chain_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stack_wir_top u_stack_wir_top (
        .clk(clk), .rst_n(rst_n), .sel_ir(sel_ir), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .ser_in(ser_in),
        .pad_prebond(pad_prebond), .ir_so(ir_so), .data_shift_en(data_shift_en),
        .chain_sel(chain_sel), .par_sel(par_sel), .ser_turn_sel(ser_turn_sel),
        .par_turn_sel(par_turn_sel), .probe_sel(probe_sel),
        .bnd_shift_sel(bnd_shift_sel), .in_cell_sel(in_cell_sel),
        .out_cell_sel(out_cell_sel)
    );

    // Entry: {code[4:0], pad, chain[1:0], par, par_turn, probe, in_cell, out_cell}
    localparam int NV = 12;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {5'b00100, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'b01101, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {5'b01010, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {5'b01111, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'b01100, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {5'b00101, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'b01000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'b01110, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'b00011, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'b01001, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        {5'b00110, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'b11101, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shift a code in LSB first, then update; outputs read after the update edge.
    task automatic load_ir(input logic [4:0] code);
        @(negedge clk);
        sel_ir = 1'b1;
        shift_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ser_in = code[i];
            @(negedge clk);
        end
        shift_en = 1'b0;
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
        sel_ir = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset mode
        check("R1 chain", {6'd0, chain_sel}, 8'h01);
        check("R1 par", {7'd0, par_sel}, 8'h00);
        check("R1 ser_turn", {7'd0, ser_turn_sel}, 8'h01);
        check("R1 par_turn", {7'd0, par_turn_sel}, 8'h01);
        check("R1 probe", {7'd0, probe_sel}, 8'h00);
        sel_ir = 1'b1;
        #1;
        check("R7 ser_turn low on load", {7'd0, ser_turn_sel}, 8'h00);
        sel_ir = 1'b0;

        // Vector table: R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            pad_prebond = VEC[i][7];
            load_ir(VEC[i][12:8]);
            check("R4 chain_sel", {6'd0, chain_sel}, {6'd0, VEC[i][6:5]});
            check("R4 par_sel", {7'd0, par_sel}, {7'd0, VEC[i][4]});
            check("R7 par_turn", {7'd0, par_turn_sel}, {7'd0, VEC[i][3]});
            check("R7 ser_turn", {7'd0, ser_turn_sel}, {7'd0, VEC[i][3]});
            check("R8 probe", {7'd0, probe_sel}, {7'd0, VEC[i][2]});
            check("R5 in_cell", {7'd0, in_cell_sel}, {7'd0, VEC[i][1]});
            check("R5 out_cell", {7'd0, out_cell_sel}, {7'd0, VEC[i][0]});
            check("R6 bnd_shift idle", {7'd0, bnd_shift_sel}, 8'h00);
            shift_en = 1'b1;
            #1;
            check("R6 bnd_shift follows", {7'd0, bnd_shift_sel}, {7'd0, VEC[i][1] | VEC[i][0]});
            check("R9 data_shift_en", {7'd0, data_shift_en}, 8'h01);
            check("R10 chain while shifting", {6'd0, chain_sel}, {6'd0, VEC[i][6:5]});
            shift_en = 1'b0;
            sel_ir = 1'b1;
            #1;
            check("R7 ser_turn during load", {7'd0, ser_turn_sel}, 8'h00);
            sel_ir = 1'b0;
        end
        pad_prebond = 1'b0;

        // R3 capture, R2 shift order and output stability
        load_ir(5'b01101);
        @(negedge clk);
        sel_ir = 1'b1;
        capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0;
        #1;
        check("R3 capture bit0", {7'd0, ir_so}, 8'h01);
        shift_en = 1'b1;
        ser_in = 1'b0;
        @(negedge clk);
        #1;
        check("R2 ir_so bit1", {7'd0, ir_so}, 8'h00);
        check("R2 hold chain", {6'd0, chain_sel}, 8'h03);
        @(negedge clk);
        #1;
        check("R2 ir_so bit2", {7'd0, ir_so}, 8'h01);
        check("R2 hold par", {7'd0, par_sel}, 8'h01);
        shift_en = 1'b0;
        sel_ir = 1'b0;

        // R3 update applies new mode
        load_ir(5'b00100);
        check("R3 new mode", {6'd0, chain_sel}, 8'h01);

        // R9 shift/update with sel_ir low leave the instruction alone
        load_ir(5'b01010);
        @(negedge clk);
        shift_en = 1'b1;
        ser_in = 1'b1;
        repeat (5) @(negedge clk);
        shift_en = 1'b0;
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
        #1;
        check("R9 ir untouched chain", {6'd0, chain_sel}, 8'h02);
        check("R9 ir untouched par_turn", {7'd0, par_turn_sel}, 8'h00);

        // R1 reset from a loaded test mode
        load_ir(5'b01101);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset chain", {6'd0, chain_sel}, 8'h01);
        check("R1 reset par", {7'd0, par_sel}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule